// File: doc/BRIEF.md
# Indexed Auto-Increment Address Pointer Bank

This block holds the address state of a scan test engine's vector memory, as seen from a processor-facing parallel bus. It keeps nine stepping registers and one master offset register. Five of the stepping registers are index counters: vector, header/trailer, macro, sequencer and bridge-support. Four are region address pointers: input-vector, output-capture, expected-data and mask. Software writes one offset into the master register. That single write relocates all four region pointers at once, and each pointer lands at its own compile-time region base plus the offset.

After that setup, the memory side pulses one access strobe for each stepping register whenever its region is touched. The matching register then moves forward by one, wrapping on overflow. The master register never steps. The block also decodes the processor address into one-hot write enables for seven control registers and one-hot read enables for four status registers. It also drives the select that steers the read capture path to memory data instead of register data.

Top module: `idx_ptr_bank`

## Requirements
- R1: After a synchronous active-high reset, the master register and all nine stepping registers read zero, and every enable output and `rd_mem` are low while no bus strobe is active.
- R2: A write to address 0 loads each region pointer with its region base plus the written data, truncated to 16 bits. Slot 5 is input-vector, base `IN_BASE`. Slot 6 is output-capture, base `OUT_BASE`. Slot 7 is expected-data, base `EXP_BASE`. Slot 8 is mask, base `MSK_BASE`. The load is visible one clock after the write.
- R3: The master register keeps the last value written to address 0, and no access strobe changes it.
- R4: A pulse on `mem_acc[s]` raises stepping register `s` by one on the next clock, and 16'hFFFF steps to 16'h0000. Slots 0..4 are the vector, header/trailer, macro, sequencer and bridge-support indices.
- R5: A write to address s+1 loads stepping register `s` with the write data. A direct write wins over a same-cycle access strobe on that slot, and so does a master write on the four pointer slots.
- R6: A stepping register with no access strobe and no write that targets it holds its value. The five index slots ignore master writes.
- R7: A write to address `CTL_BASE`+k, for k in 0..6, raises only `ctl_wen[k]` in that cycle. Reads never raise `ctl_wen`.
- R8: A read of address `STS_BASE`+k, for k in 0..3, raises only `sts_ren[k]` in that cycle. Writes never raise `sts_ren`.
- R9: `rd_mem` is high exactly when `rd_en` is high and the address is at or above `MEM_BASE`.
- R10: `rdata` shows the value at `addr`, combinationally. Address 0 gives the master register, addresses 1..9 give stepping slots 0..8, and every other address gives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe |
| addr | input | AW | Bus register address |
| wdata | input | DW | Bus write data |
| mem_acc | input | 9 | Per-slot region access strobes |
| rdata | output | DW | Register readback for `addr` |
| slot_q | output | 9 x DW | Current values of the stepping registers |
| ctl_wen | output | 7 | One-hot control register write enables |
| sts_ren | output | 4 | One-hot status register read enables |
| rd_mem | output | 1 | Read capture select: 1 = memory, 0 = register |

## Verification
The assertions check four things on every clock. After a master write, every pointer sits at its base plus the offset. Each slot steps by exactly one on an undisturbed access, or holds still when nothing touches it. A direct write wins over a same-cycle strobe. The decoded enables stay one-hot and follow the right strobe direction. Three properties show up only through the bench's directed scenarios: the concrete relocation values with 16-bit wrap, the readback address map including the zero-returning holes, and the master register staying put across access traffic.

// File: rtl/ipb_pkg.sv
package ipb_pkg;
  localparam int NIDX  = 5;
  localparam int NPTR  = 4;
  localparam int NSLOT = NIDX + NPTR;
  localparam int NCTL  = 7;
  localparam int NSTS  = 4;

  typedef enum logic [1:0] {
    RGN_IN  = 2'd0,
    RGN_OUT = 2'd1,
    RGN_EXP = 2'd2,
    RGN_MSK = 2'd3
  } region_e;

  // slot position of a region pointer inside the stepping bank
  function automatic int ptr_slot(input region_e r);
    return NIDX + int'(r);
  endfunction
endpackage

// File: rtl/ipb_addr_dec.sv
module ipb_addr_dec
  import ipb_pkg::*;
#(
  parameter int AW = 6,
  parameter logic [AW-1:0] CTL_BASE = 6'h10,
  parameter logic [AW-1:0] STS_BASE = 6'h18,
  parameter logic [AW-1:0] MEM_BASE = 6'h20
) (
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  output logic             mst_wr,
  output logic [NSLOT-1:0] slot_wr,
  output logic [NCTL-1:0]  ctl_wen,
  output logic [NSTS-1:0]  sts_ren,
  output logic             rd_mem
);
  assign mst_wr = wr_en && (addr == '0);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign slot_wr[s] = wr_en && (addr == AW'(s + 1));
  end

  for (genvar k = 0; k < NCTL; k++) begin : g_ctl
    assign ctl_wen[k] = wr_en && (addr == CTL_BASE + AW'(k));
  end

  for (genvar k = 0; k < NSTS; k++) begin : g_sts
    assign sts_ren[k] = rd_en && (addr == STS_BASE + AW'(k));
  end

  assign rd_mem = rd_en && (addr >= MEM_BASE);
endmodule

// File: rtl/ipb_step_reg.sv
module ipb_step_reg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  input  logic          inc,
  output logic [DW-1:0] q
);
  function automatic logic [DW-1:0] step(input logic [DW-1:0] v);
    return v + DW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (ld)   q <= ld_val;
    else if (inc)  q <= step(q);
  end
endmodule

// File: rtl/idx_ptr_bank.sv
module idx_ptr_bank
  import ipb_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 6,
  parameter logic [DW-1:0] IN_BASE  = 16'h0000,
  parameter logic [DW-1:0] OUT_BASE = 16'h4000,
  parameter logic [DW-1:0] EXP_BASE = 16'h8000,
  parameter logic [DW-1:0] MSK_BASE = 16'hC000,
  parameter logic [AW-1:0] CTL_BASE = 6'h10,
  parameter logic [AW-1:0] STS_BASE = 6'h18,
  parameter logic [AW-1:0] MEM_BASE = 6'h20
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             wdata,
  input  logic [NSLOT-1:0]          mem_acc,
  output logic [DW-1:0]             rdata,
  output logic [NSLOT-1:0][DW-1:0]  slot_q,
  output logic [NCTL-1:0]           ctl_wen,
  output logic [NSTS-1:0]           sts_ren,
  output logic                      rd_mem
);
  localparam logic [NPTR-1:0][DW-1:0] BASES = {MSK_BASE, EXP_BASE, OUT_BASE, IN_BASE};

  function automatic logic [DW-1:0] relocate(input logic [DW-1:0] base,
                                             input logic [DW-1:0] off);
    return base + off;
  endfunction

  // named internal events
  logic             mst_wr;
  logic [NSLOT-1:0] slot_wr;
  logic [NSLOT-1:0] slot_ld;
  logic [NSLOT-1:0][DW-1:0] slot_ld_val;
  logic [DW-1:0]    mst_q;

  ipb_addr_dec #(
    .AW(AW), .CTL_BASE(CTL_BASE), .STS_BASE(STS_BASE), .MEM_BASE(MEM_BASE)
  ) i_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .mst_wr(mst_wr), .slot_wr(slot_wr),
    .ctl_wen(ctl_wen), .sts_ren(sts_ren), .rd_mem(rd_mem)
  );

  always_ff @(posedge clk) begin
    if (rst)         mst_q <= '0;
    else if (mst_wr) mst_q <= wdata;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_bank
    if (s < NIDX) begin : g_idx
      assign slot_ld[s]     = slot_wr[s];
      assign slot_ld_val[s] = wdata;
    end else begin : g_ptr
      assign slot_ld[s]     = slot_wr[s] | mst_wr;
      assign slot_ld_val[s] = slot_wr[s] ? wdata : relocate(BASES[s - NIDX], wdata);
    end
    ipb_step_reg #(.DW(DW)) i_reg (
      .clk(clk), .rst(rst), .ld(slot_ld[s]), .ld_val(slot_ld_val[s]),
      .inc(mem_acc[s]), .q(slot_q[s])
    );
  end

  always_comb begin
    rdata = '0;
    if (addr == '0) rdata = mst_q;
    for (int s = 0; s < NSLOT; s++) begin
      if (addr == AW'(s + 1)) rdata = slot_q[s];
    end
  end
endmodule

// File: rtl/ipb_chk.sv
module ipb_chk
  import ipb_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 6,
  parameter logic [DW-1:0] IN_BASE  = 16'h0000,
  parameter logic [DW-1:0] OUT_BASE = 16'h4000,
  parameter logic [DW-1:0] EXP_BASE = 16'h8000,
  parameter logic [DW-1:0] MSK_BASE = 16'hC000
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic                     rd_en,
  input logic [AW-1:0]            addr,
  input logic [DW-1:0]            wdata,
  input logic [NSLOT-1:0]         mem_acc,
  input logic [NSLOT-1:0][DW-1:0] slot_q,
  input logic [NCTL-1:0]          ctl_wen,
  input logic [NSTS-1:0]          sts_ren,
  input logic                     rd_mem
);
  wire mst_hit = wr_en && (addr == '0);

  // R2
  in_reloc_chk: assert property (@(posedge clk) disable iff (rst)
    mst_hit |=> slot_q[NIDX+0] == DW'(IN_BASE + $past(wdata)));
  // R2
  out_reloc_chk: assert property (@(posedge clk) disable iff (rst)
    mst_hit |=> slot_q[NIDX+1] == DW'(OUT_BASE + $past(wdata)));
  // R2
  exp_reloc_chk: assert property (@(posedge clk) disable iff (rst)
    mst_hit |=> slot_q[NIDX+2] == DW'(EXP_BASE + $past(wdata)));
  // R2
  msk_reloc_chk: assert property (@(posedge clk) disable iff (rst)
    mst_hit |=> slot_q[NIDX+3] == DW'(MSK_BASE + $past(wdata)));

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    wire own_hit = wr_en && (addr == AW'(s + 1));
    wire any_ld  = own_hit || ((s >= NIDX) && mst_hit);
    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
      (mem_acc[s] && !any_ld) |=> slot_q[s] == DW'($past(slot_q[s]) + 1));
    // R5
    wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
      own_hit |=> slot_q[s] == $past(wdata));
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!mem_acc[s] && !any_ld) |=> $stable(slot_q[s]));
  end

  // R7
  ctl_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctl_wen));
  // R7
  ctl_dir_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> ctl_wen == '0);
  // R8
  sts_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sts_ren));
  // R8
  sts_dir_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> sts_ren == '0);
  // R9
  mem_sel_chk: assert property (@(posedge clk) disable iff (rst)
    rd_mem |-> rd_en);
endmodule

bind idx_ptr_bank ipb_chk #(
  .DW(DW), .AW(AW), .IN_BASE(IN_BASE), .OUT_BASE(OUT_BASE),
  .EXP_BASE(EXP_BASE), .MSK_BASE(MSK_BASE)
) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .mem_acc(mem_acc), .slot_q(slot_q), .ctl_wen(ctl_wen),
  .sts_ren(sts_ren), .rd_mem(rd_mem)
);

// File: tb/test_idx_ptr_bank.sv
module test_idx_ptr_bank;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int NS = 9;
  localparam logic [DW-1:0] B_IN = 16'h0000, B_OUT = 16'h4000,
                            B_EXP = 16'h8000, B_MSK = 16'hC000;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NS-1:0] mem_acc = '0;
  logic [DW-1:0] rdata;
  logic [NS-1:0][DW-1:0] slot_q;
  logic [6:0] ctl_wen;
  logic [3:0] sts_ren;
  logic rd_mem;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_ptr_bank i_idx_ptr_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .mem_acc(mem_acc), .rdata(rdata), .slot_q(slot_q),
    .ctl_wen(ctl_wen), .sts_ren(sts_ren), .rd_mem(rd_mem)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock with the given strobes; starts and ends at a negedge
  task automatic cyc(input logic w, input logic r, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic [NS-1:0] acc);
    wr_en = w; rd_en = r; addr = a; wdata = d; mem_acc = acc;
    @(posedge clk); @(negedge clk);
    wr_en = 0; rd_en = 0; mem_acc = '0;
  endtask

  function automatic logic [DW-1:0] add16(input logic [DW-1:0] b, input logic [DW-1:0] o);
    logic [DW:0] t = {1'b0, b} + {1'b0, o};
    return t[DW-1:0];
  endfunction

  task automatic t_reset;
    for (int a = 0; a < 10; a++) begin
      addr = AW'(a); #1;
      chk("R1 readback", rdata, 0);
    end
    chk("R1 slots", slot_q, '0);
    chk("R1 enables", {ctl_wen, sts_ren, rd_mem}, 0);
  endtask

  task automatic t_master;
    cyc(1, 0, 6'd0, 16'h5000, '0);
    chk("R2 in",  slot_q[5], add16(B_IN,  16'h5000));
    chk("R2 out", slot_q[6], add16(B_OUT, 16'h5000));
    chk("R2 exp", slot_q[7], add16(B_EXP, 16'h5000));
    chk("R2 msk wrap", slot_q[8], 16'h1000);
    for (int s = 0; s < 5; s++) chk("R6 idx untouched", slot_q[s], 0);
    addr = 6'd0; #1;
    chk("R10 master readback", rdata, 16'h5000);
  endtask

  task automatic t_step;
    for (int i = 0; i < 3; i++) cyc(0, 0, 6'd0, '0, NS'(1) << 5);
    chk("R4 in ptr x3", slot_q[5], 16'h5003);
    chk("R6 out ptr holds", slot_q[6], 16'h9000);
    cyc(0, 0, 6'd0, '0, 9'b000010101);
    chk("R4 vec idx", slot_q[0], 1);
    chk("R4 macro idx", slot_q[2], 1);
    chk("R4 bridge idx", slot_q[4], 1);
    chk("R6 hdr idx holds", slot_q[1], 0);
    cyc(1, 0, 6'd9, 16'hFFFF, '0);
    chk("R5 direct load", slot_q[8], 16'hFFFF);
    cyc(0, 0, 6'd0, '0, NS'(1) << 8);
    chk("R4 wrap", slot_q[8], 0);
    addr = 6'd0; #1;
    chk("R3 master holds", rdata, 16'h5000);
    addr = 6'd6; #1;
    chk("R10 slot5 readback", rdata, 16'h5003);
  endtask

  task automatic t_prio;
    cyc(1, 0, 6'd2, 16'h1234, NS'(1) << 1);
    chk("R5 write beats step", slot_q[1], 16'h1234);
    cyc(1, 0, 6'd0, 16'h0010, 9'b111100000);
    chk("R5 master beats step in",  slot_q[5], add16(B_IN,  16'h0010));
    chk("R5 master beats step msk", slot_q[8], add16(B_MSK, 16'h0010));
    chk("R6 idx ignore master", slot_q[1], 16'h1234);
    addr = 6'd0; #1;
    chk("R3 master new", rdata, 16'h0010);
  endtask

  task automatic t_ctl;
    for (int k = 0; k < 7; k++) begin
      wr_en = 1; addr = AW'(6'h10 + k); #1;
      chk("R7 ctl onehot", ctl_wen, 7'(1) << k);
      wr_en = 0; rd_en = 1; #1;
      chk("R7 read no ctl", ctl_wen, 0);
      rd_en = 0;
    end
    wr_en = 1; addr = 6'h17; #1;
    chk("R7 past end", ctl_wen, 0);
    wr_en = 0;
  endtask

  task automatic t_sts;
    for (int k = 0; k < 4; k++) begin
      rd_en = 1; addr = AW'(6'h18 + k); #1;
      chk("R8 sts onehot", sts_ren, 4'(1) << k);
      rd_en = 0; wr_en = 1; #1;
      chk("R8 write no sts", sts_ren, 0);
      wr_en = 0;
    end
    #1;
  endtask

  task automatic t_mem;
    rd_en = 1; addr = 6'h20; #1; chk("R9 mem low edge", rd_mem, 1);
    addr = 6'h3F; #1; chk("R9 mem top", rd_mem, 1);
    addr = 6'h1F; #1; chk("R9 reg side", rd_mem, 0);
    rd_en = 0; wr_en = 1; addr = 6'h20; #1; chk("R9 write no mem", rd_mem, 0);
    wr_en = 0;
    addr = 6'h0A; #1; chk("R10 hole", rdata, 0);
    addr = 6'h10; #1; chk("R10 ctl addr reads zero", rdata, 0);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_master();
    t_step();
    t_prio();
    t_ctl();
    t_sts();
    t_mem();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule